// File: doc/BRIEF.md
# Integer ALU with Compare Flags

This block is the arithmetic and logic unit of a simple RISC integer datapath. It is purely combinational. It takes two 32-bit operands and a 4-bit operation code, and it returns a 32-bit result, a zero flag and an overflow flag. Add and subtract share one carry chain. For subtraction the B operand is inverted and the carry-in is forced to 1.

The set-on-less-than operations, signed and unsigned, reuse that same subtraction and return 0 or 1 in bit 0 of the result. Branch equality is tested by issuing a subtract and reading the zero flag. Immediate extension, shifts, multiply and divide are handled elsewhere in the datapath. The instruction decoder drives a per-operation input that states whether a signed overflow should be reported.

Top module: `int_alu`

## Requirements
- R1: Code 4'b0010 (add) returns (A + B) mod 2^32. Unsigned wrap-around alone never sets the overflow flag.
- R2: Code 4'b0110 (subtract) returns (A - B) mod 2^32.
- R3: The overflow output is 1 exactly when check_ovf_i is 1, the code is add or subtract, and the two's-complement result does not fit in 32 bits. When check_ovf_i is 0 the output is always 0.
- R4: For every code other than add and subtract, the overflow output is 0, whatever the operands and check_ovf_i.
- R5: The bitwise operations use these codes: 4'b0000 AND, 4'b0001 OR, 4'b1101 XOR, 4'b1100 NOR.
- R6: Code 4'b0111 returns 1 in bit 0 when A < B as signed numbers, otherwise 0. Bits 31..1 are 0. The answer stays correct when A - B overflows.
- R7: Code 4'b1000 returns 1 in bit 0 when A < B as unsigned numbers, otherwise 0. Bits 31..1 are 0.
- R8: Every code not listed in R1, R2 and R5 to R7 returns a result of 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0, for every code.
- R10: A subtract with equal operands raises the zero flag. A subtract with unequal operands leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 4 | Operation code |
| check_ovf_i | input | 1 | Enables overflow reporting for this operation |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract, gated by check_ovf_i |

## Verification
Every output of this block depends only on the current inputs, so all three results are due in the same cycle as the stimulus, with no register in between. The bench applies each operand set just after a rising clock edge and reads result, zero and overflow at the following falling edge. By then the combinational paths have settled, and the next stimulus has not yet been applied. Corner operands are chosen to reach both overflow directions, signed comparisons whose subtraction overflows, unsigned wrap-around and every unused code.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SLTU = 4'b1000,
    OP_NOR  = 4'b1100,
    OP_XOR  = 4'b1101
  } alu_op_e;

  function automatic logic uses_subtract(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out_o,
  output logic             ovf_o
);
  localparam int LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [LOW_W-1:0] low_sum;
  logic             carry_msb_in;
  logic             msb_sum;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign {carry_msb_in, low_sum} = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                                   + {{LOW_W{1'b0}}, sub_i};
  assign {carry_out_o, msb_sum}  = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                                   + {1'b0, carry_msb_in};
  assign sum_o = {msb_sum, low_sum};
  // signed overflow from the two carries around the top bit
  assign ovf_o = carry_msb_in ^ carry_out_o;

  always_comb begin
    // R2: carry chain agrees with a native difference
    p_sub_value_r2: assert (!sub_i || sum_o == a_i - b_i)
      else $error("p_sub_value_r2");
    // R1: carry chain agrees with a native sum
    p_add_value_r1: assert (sub_i || sum_o == a_i + b_i)
      else $error("p_add_value_r1");
    // R3: overflow only when operand signs match after inversion and the result sign flips
    p_ovf_sign_r3: assert (!ovf_o ||
                           (a_i[WIDTH-1] == b_eff[WIDTH-1] && sum_o[WIDTH-1] != a_i[WIDTH-1]))
      else $error("p_ovf_sign_r3");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign xor_o = a_i ^ b_i;
  assign nor_o = ~or_o;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int OP_W   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             check_ovf_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] sum;
  logic             carry_out;
  logic             ovf_raw;
  logic [WIDTH-1:0] and_r, or_r, xor_r, nor_r;
  logic             lt_signed, lt_unsigned;
  logic             arith_op;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i        (a_i),
    .b_i        (b_i),
    .sub_i      (uses_subtract(op_i)),
    .sum_o      (sum),
    .carry_out_o(carry_out),
    .ovf_o      (ovf_raw)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .and_o(and_r),
    .or_o (or_r),
    .xor_o(xor_r),
    .nor_o(nor_r)
  );

  // sign corrected by overflow; unsigned borrow is the missing carry
  assign lt_signed   = sum[WIDTH-1] ^ ovf_raw;
  assign lt_unsigned = ~carry_out;

  always_comb begin
    case (op_i)
      OP_AND:  result_o = and_r;
      OP_OR:   result_o = or_r;
      OP_XOR:  result_o = xor_r;
      OP_NOR:  result_o = nor_r;
      OP_ADD,
      OP_SUB:  result_o = sum;
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, lt_unsigned};
      default: result_o = '0;
    endcase
  end

  assign arith_op = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign zero_o   = ~|result_o;
  assign ovf_o    = check_ovf_i & arith_op & ovf_raw;

  always_comb begin
    p_ovf_gate_r3: assert (check_ovf_i || !ovf_o) else $error("p_ovf_gate_r3");
    p_no_ovf_r4: assert (arith_op || !ovf_o) else $error("p_no_ovf_r4");
    p_slt_upper_r6: assert (op_i != OP_SLT || result_o[WIDTH-1:1] == '0)
      else $error("p_slt_upper_r6");
    p_slt_value_r6: assert (op_i != OP_SLT || result_o[0] == ($signed(a_i) < $signed(b_i)))
      else $error("p_slt_value_r6");
    p_sltu_value_r7: assert (op_i != OP_SLTU || result_o == {{(WIDTH-1){1'b0}}, a_i < b_i})
      else $error("p_sltu_value_r7");
    p_eq_zero_r10: assert (op_i != OP_SUB || zero_o == (a_i == b_i))
      else $error("p_eq_zero_r10");
  end
endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
  localparam int W  = 32;
  localparam int NV = 22;
  localparam int VW = 4 + 1 + 3*W + 1 + 1 + 4;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, res;
  logic [3:0]   op;
  logic         chk, zero, ovf;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;

  always #2.5 clk = ~clk;

  int_alu u_int_alu (
    .a_i(a), .b_i(b), .op_i(op), .check_ovf_i(chk),
    .result_o(res), .zero_o(zero), .ovf_o(ovf)
  );

  // {op, check, a, b, result, zero, ovf, requirement}
  localparam logic [VW-1:0] VECS [NV] = '{
    {4'h2,1'b1,32'h00000007,32'h00000005,32'h0000000C,1'b0,1'b0,4'd1},  // R1
    {4'h2,1'b1,32'h7FFFFFFF,32'h00000001,32'h80000000,1'b0,1'b1,4'd3},  // R3 pos+pos
    {4'h2,1'b0,32'h7FFFFFFF,32'h00000001,32'h80000000,1'b0,1'b0,4'd3},  // R3 gated
    {4'h2,1'b1,32'h80000000,32'h80000000,32'h00000000,1'b1,1'b1,4'd3},  // R3 neg+neg
    {4'h2,1'b1,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b1,1'b0,4'd1},  // R1 wrap
    {4'h6,1'b1,32'h00000007,32'h00000006,32'h00000001,1'b0,1'b0,4'd2},  // R2
    {4'h6,1'b1,32'h80000000,32'h00000001,32'h7FFFFFFF,1'b0,1'b1,4'd3},  // R3 sub
    {4'h6,1'b1,32'h12345678,32'h12345678,32'h00000000,1'b1,1'b0,4'd10}, // R10
    {4'h6,1'b1,32'h00000003,32'h00000005,32'hFFFFFFFE,1'b0,1'b0,4'd2},  // R2 neg
    {4'h0,1'b1,32'hF0F0F0F0,32'hFF00FF00,32'hF000F000,1'b0,1'b0,4'd5},  // R5 and
    {4'h1,1'b1,32'hF0F0F0F0,32'hFF00FF00,32'hFFF0FFF0,1'b0,1'b0,4'd5},  // R5 or
    {4'hD,1'b1,32'hF0F0F0F0,32'hFF00FF00,32'h0FF00FF0,1'b0,1'b0,4'd5},  // R5 xor
    {4'hC,1'b1,32'hF0F0F0F0,32'hFF00FF00,32'h000F000F,1'b0,1'b0,4'd5},  // R5 nor
    {4'h7,1'b1,32'hFFFFFFFF,32'h00000001,32'h00000001,1'b0,1'b0,4'd6},  // R6
    {4'h7,1'b1,32'h80000000,32'h00000001,32'h00000001,1'b0,1'b0,4'd6},  // R6 ovf case
    {4'h7,1'b1,32'h7FFFFFFF,32'hFFFFFFFF,32'h00000000,1'b1,1'b0,4'd6},  // R6 ovf case
    {4'h8,1'b1,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b1,1'b0,4'd7},  // R7
    {4'h8,1'b1,32'h00000001,32'hFFFFFFFF,32'h00000001,1'b0,1'b0,4'd7},  // R7
    {4'h8,1'b1,32'h00000005,32'h00000005,32'h00000000,1'b1,1'b0,4'd7},  // R7 equal
    {4'h3,1'b1,32'h7FFFFFFF,32'h00000001,32'h00000000,1'b1,1'b0,4'd8},  // R8
    {4'hF,1'b1,32'hFFFFFFFF,32'hFFFFFFFF,32'h00000000,1'b1,1'b0,4'd8},  // R8
    {4'h0,1'b1,32'h0F0F0F0F,32'hF0F0F0F0,32'h00000000,1'b1,1'b0,4'd9}   // R9
  };

  task automatic check(input string tag, input logic [W-1:0] er,
                       input logic ez, input logic eo);
    checks++;
    if (res !== er || zero !== ez || ovf !== eo) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h: got res=%h z=%b o=%b, expected res=%h z=%b o=%b",
               tag, op, a, b, res, zero, ovf, er, ez, eo);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic c,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    op = o; chk = c; a = x; b = y;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 4'h0; chk = 1'b0; a = '0; b = '0;
    @(negedge clk);
    // initial state, all inputs zero: AND of zeros (R9)
    check("R9 idle", 32'h0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      apply(v[VW-1 -: 4], v[VW-5], v[VW-6 -: W], v[VW-6-W -: W]);
      check($sformatf("R%0d vec%0d", v[3:0], i), v[VW-6-2*W -: W], v[5], v[4]);
    end

    // R4/R3: every code with a subtract-overflow operand pair; only SUB may flag
    for (int c = 0; c < 16; c++) begin
      apply(c[3:0], 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF);
      checks++;
      if (ovf !== (c == 6)) begin
        errors++;
        $display("FAIL R4 code=%h: got ovf=%b, expected %b", c[3:0], ovf, (c == 6));
      end
    end

    // R10: subtract of unequal values differing only in the top bit
    apply(4'h6, 1'b0, 32'h80000000, 32'h00000000);
    check("R10 unequal", 32'h80000000, 1'b0, 1'b0);
    // R3: negative minus positive overflow gated off
    apply(4'h6, 1'b0, 32'h80000000, 32'h00000001);
    check("R3 gated sub", 32'h7FFFFFFF, 1'b0, 1'b0);
    // R6: equal signed operands
    apply(4'h7, 1'b1, 32'h80000000, 32'h80000000);
    check("R6 equal", 32'h0, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule